// File: doc/BRIEF.md
# Multi-Protocol PHY Configuration Register

This block is the host-visible 32-bit configuration register of a serial PHY that can carry PCIe, USB3 or SATA traffic. It has a single-cycle host port with valid, write enable and write data. The read data always shows the current register contents, and the ready output is tied high. Two fields drive PHY controls directly. One bit turns bypass of the line encoder/decoder on or off. Another bit enables the reference clock that is driven out to the endpoint.

The register also works as a window into a small internal test-register file of 32 four-bit entries. Software places a 5-bit entry address and a 4-bit data value in packed fields of the register. The write into the file happens only when the strobe bit of the same register goes from 0 to 1. The expected software sequence has three writes. First it writes the address and data with the strobe left as it was. Then it clears the strobe. Then it sets the strobe. That sequence gives exactly one internal write. Rewriting the register while the strobe is already 1 never repeats the write.

A separate read port returns the entry at any 5-bit address in the same cycle. Bench and diagnostic logic use it to inspect the file.

Top module: `phy_cfg_reg`

## Requirements
- R1: After reset the register reads 0x8000_0000: codec bypass on, strobe 0, clock output disabled, address and data fields 0.
- R2: `bus_ready` is always 1. A cycle with `bus_valid`=1 and `bus_we`=1 loads the register at that clock edge. A cycle without both leaves it unchanged.
- R3: Bit 31 is the codec bypass. `codec_bypass` follows the stored bit, where 1 means bypass and 0 means encoding and decoding are enabled.
- R4: Bit 0 is the reference clock output enable. `refclk_oe` follows the stored bit, where 1 drives the clock.
- R5: Bits 16:12 (entry address), bits 23:20 (entry data) and bit 24 (strobe) read back the last value written.
- R6: All bits other than 31, 24, 23:20, 16:12 and 0 read as 0 and ignore writes. Writing 0xFFFF_FFFF reads back 0x81F1_F001.
- R7: A register write whose bit 24 is 1 while the stored bit 24 is 0 writes the data field into the entry named by the address field, at the same clock edge.
- R8: A register write that leaves bit 24 at 1, or writes it as 0, changes no test-register entry.
- R9: The three-step sequence (fields with the strobe unchanged, strobe cleared, strobe set) results in exactly one entry update.
- R10: `tr_rdata` shows the entry addressed by `tr_raddr` combinationally, in the same cycle.
- R11: The test-register file holds 32 entries of 4 bits, all 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Host access valid |
| bus_we | input | 1 | Host access is a write |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Current register contents |
| bus_ready | output | 1 | Access accepted, always 1 |
| codec_bypass | output | 1 | Line codec bypass control |
| refclk_oe | output | 1 | Endpoint reference clock output enable |
| tr_raddr | input | 5 | Test-register read address |
| tr_rdata | output | 4 | Test-register entry at `tr_raddr` |

## Verification
The assertions assume that `bus_valid` and `bus_we` are driven low during reset. This matters because the entry-update check looks one cycle back at the internal write pulse. The bench holds both inputs low until reset is released and drives every access away from the active edge. The assertions also assume that the host keeps `bus_we` meaningful only while `bus_valid` is high. The bench raises both together for a single cycle per write, and uses a valid cycle without write enable only to show that reads change nothing.

// File: rtl/phy_cfg_pkg.sv
package phy_cfg_pkg;
  localparam int REG_W    = 32;
  localparam int BYP_BIT  = 31;
  localparam int STB_BIT  = 24;
  localparam int DATA_LSB = 20;
  localparam int DATA_W   = 4;
  localparam int ADDR_LSB = 12;
  localparam int ADDR_W   = 5;
  localparam int OE_BIT   = 0;
  localparam int TF_DEPTH = 1 << ADDR_W;

  function automatic logic [REG_W-1:0] field_mask(input int lsb, input int w);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < w; i++) m[lsb+i] = 1'b1;
    return m;
  endfunction

  localparam logic [REG_W-1:0] LIVE_MASK =
    field_mask(BYP_BIT, 1) | field_mask(STB_BIT, 1) |
    field_mask(DATA_LSB, DATA_W) | field_mask(ADDR_LSB, ADDR_W) |
    field_mask(OE_BIT, 1);

  localparam logic [REG_W-1:0] RESET_VAL = field_mask(BYP_BIT, 1);
endpackage

// File: rtl/phy_cfg_ctrl.sv
module phy_cfg_ctrl
  import phy_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  cfg_q,
  output logic              tf_we,
  output logic [ADDR_W-1:0] tf_waddr,
  output logic [DATA_W-1:0] tf_wdata
);
  logic [REG_W-1:0] cfg_d;
  logic             cfg_en;

  // next state: only defined bits survive
  always_comb begin
    cfg_en = wr_en;
    cfg_d  = wdata & LIVE_MASK;
  end

  // strobe rising edge between stored and incoming value
  always_comb begin
    tf_we    = cfg_en & cfg_d[STB_BIT] & ~cfg_q[STB_BIT];
    tf_waddr = cfg_d[ADDR_LSB +: ADDR_W];
    tf_wdata = cfg_d[DATA_LSB +: DATA_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= RESET_VAL;
    else if (cfg_en) cfg_q <= cfg_d;
  end
endmodule

// File: rtl/phy_cfg_testfile.sv
module phy_cfg_testfile #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [DEPTH-1:0] sel;

  always_comb begin
    sel = '0;
    sel[waddr] = we;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mem[i] <= '0;
      else if (sel[i]) mem[i] <= wdata;
    end
  end

  always_comb rdata = mem[raddr];
endmodule

// File: rtl/phy_cfg_reg.sv
module phy_cfg_reg
  import phy_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              bus_ready,
  output logic              codec_bypass,
  output logic              refclk_oe,
  input  logic [ADDR_W-1:0] tr_raddr,
  output logic [DATA_W-1:0] tr_rdata
);
  logic              wr_en;
  logic [REG_W-1:0]  cfg_q;
  logic              tf_we;
  logic [ADDR_W-1:0] tf_waddr;
  logic [DATA_W-1:0] tf_wdata;

  assign wr_en     = bus_valid & bus_we;
  assign bus_ready = 1'b1;

  phy_cfg_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wdata    (bus_wdata),
    .cfg_q    (cfg_q),
    .tf_we    (tf_we),
    .tf_waddr (tf_waddr),
    .tf_wdata (tf_wdata)
  );

  phy_cfg_testfile #(.DEPTH(TF_DEPTH), .WIDTH(DATA_W)) u_tf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (tf_we),
    .waddr (tf_waddr),
    .wdata (tf_wdata),
    .raddr (tr_raddr),
    .rdata (tr_rdata)
  );

  assign bus_rdata    = cfg_q;
  assign codec_bypass = cfg_q[BYP_BIT];
  assign refclk_oe    = cfg_q[OE_BIT];
endmodule

// File: rtl/phy_cfg_reg_chk.sv
module phy_cfg_reg_chk
  import phy_cfg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_we,
  input logic [REG_W-1:0]  bus_wdata,
  input logic [REG_W-1:0]  bus_rdata,
  input logic              bus_ready,
  input logic              codec_bypass,
  input logic              refclk_oe,
  input logic [ADDR_W-1:0] tr_raddr,
  input logic [DATA_W-1:0] tr_rdata,
  input logic              tf_we,
  input logic [ADDR_W-1:0] tf_waddr,
  input logic [DATA_W-1:0] tf_wdata
);
  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n) bus_ready); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && bus_we) |=> $stable(bus_rdata)); // R2
  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_we) |=> bus_rdata == ($past(bus_wdata) & LIVE_MASK)); // R5
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~LIVE_MASK) == '0); // R6
  AST_BYPASS_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_we) |=> codec_bypass == $past(bus_wdata[BYP_BIT])); // R3
  AST_OE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_we) |=> refclk_oe == $past(bus_wdata[OE_BIT])); // R4
  AST_FIRE_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    tf_we |-> !bus_rdata[STB_BIT]); // R7
  AST_FIRE_LEAVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    tf_we |=> bus_rdata[STB_BIT]); // R7
  AST_NO_REFIRE: assert property (@(posedge clk) disable iff (!rst_n)
    tf_we |=> !tf_we); // R8
  AST_ENTRY_UPDATED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tf_we) && tr_raddr == $past(tf_waddr)) |-> tr_rdata == $past(tf_wdata)); // R7
endmodule

bind phy_cfg_reg phy_cfg_reg_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_valid    (bus_valid),
  .bus_we       (bus_we),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .bus_ready    (bus_ready),
  .codec_bypass (codec_bypass),
  .refclk_oe    (refclk_oe),
  .tr_raddr     (tr_raddr),
  .tr_rdata     (tr_rdata),
  .tf_we        (tf_we),
  .tf_waddr     (tf_waddr),
  .tf_wdata     (tf_wdata)
);

// File: tb/phy_cfg_reg_test.sv
module phy_cfg_reg_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_valid;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_ready;
  logic        codec_bypass;
  logic        refclk_oe;
  logic [4:0]  tr_raddr;
  logic [3:0]  tr_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic strobe_sw;

  phy_cfg_reg uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .codec_bypass(codec_bypass), .refclk_oe(refclk_oe),
    .tr_raddr(tr_raddr), .tr_rdata(tr_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [31:0] v);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b1; bus_wdata = v;
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0;
  endtask

  function automatic logic [31:0] mk(input logic byp, input logic stb,
                                     input logic [3:0] d, input logic [4:0] a,
                                     input logic oe);
    return {byp, 6'd0, stb, d, 3'd0, a, 11'd0, oe};
  endfunction

  task automatic entry_is(input string req, input logic [4:0] a, input logic [3:0] exp);
    tr_raddr = a;
    #1;
    check(req, {28'd0, tr_rdata}, {28'd0, exp});
  endtask

  // three-step indirect write, bypass off, clock output on
  task automatic indirect_write(input logic [4:0] a, input logic [3:0] d);
    bus_write(mk(1'b0, strobe_sw, d, a, 1'b1));
    bus_write(mk(1'b0, 1'b0, d, a, 1'b1));
    bus_write(mk(1'b0, 1'b1, d, a, 1'b1));
    strobe_sw = 1'b1;
  endtask

  task automatic t_reset;
    check("R1 reset value", bus_rdata, 32'h8000_0000);
    check("R2 ready", {31'd0, bus_ready}, 32'd1);
    check("R3 bypass at reset", {31'd0, codec_bypass}, 32'd1);
    check("R4 clock oe at reset", {31'd0, refclk_oe}, 32'd0);
    for (int i = 0; i < 32; i++) entry_is("R11 entry reset", i[4:0], 4'h0);
  endtask

  task automatic t_fields;
    bus_write(32'hFFFF_FFFF);
    check("R6 all-ones readback", bus_rdata, 32'h81F1_F001);
    check("R5 strobe/data/addr readback", bus_rdata & 32'h01F1_F000, 32'h01F1_F000);
    check("R3 bypass set", {31'd0, codec_bypass}, 32'd1);
    check("R4 clock oe set", {31'd0, refclk_oe}, 32'd1);
    entry_is("R7 rise from reset strobe", 5'd31, 4'hF);
    bus_write(32'h7E0E_0FFE);
    check("R6 reserved ignored", bus_rdata, 32'h0000_0000);
    check("R3 bypass cleared", {31'd0, codec_bypass}, 32'd0);
    check("R4 clock oe cleared", {31'd0, refclk_oe}, 32'd0);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b0; bus_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    bus_valid = 1'b0;
    check("R2 read cycle changes nothing", bus_rdata, 32'h0000_0000);
    bus_write(mk(1'b0, 1'b0, 4'hA, 5'd9, 1'b0));
    check("R5 fields readback", bus_rdata, 32'h00A0_9000);
    entry_is("R8 strobe low no write", 5'd9, 4'h0);
    strobe_sw = 1'b0;
  endtask

  task automatic t_sequence;
    indirect_write(5'd1, 4'h8);
    indirect_write(5'd12, 4'h9);
    indirect_write(5'd26, 4'h4);
    entry_is("R9 entry 1", 5'd1, 4'h8);
    entry_is("R9 entry 12", 5'd12, 4'h9);
    entry_is("R9 entry 26", 5'd26, 4'h4);
    entry_is("R9 other entry untouched", 5'd0, 4'h0);
    entry_is("R9 entry 31 kept", 5'd31, 4'hF);
    check("R4 oe during sequence", {31'd0, refclk_oe}, 32'd1);
  endtask

  task automatic t_no_refire;
    // strobe already 1: new fields must not land
    bus_write(mk(1'b0, 1'b1, 4'h3, 5'd1, 1'b1));
    entry_is("R8 held strobe no write", 5'd1, 4'h8);
    bus_write(mk(1'b0, 1'b1, 4'h6, 5'd12, 1'b1));
    entry_is("R8 held strobe again", 5'd12, 4'h9);
    bus_write(mk(1'b0, 1'b0, 4'h5, 5'd2, 1'b1));
    entry_is("R8 falling strobe no write", 5'd2, 4'h0);
    bus_write(mk(1'b0, 1'b1, 4'h5, 5'd2, 1'b1));
    entry_is("R7 rise writes entry", 5'd2, 4'h5);
    entry_is("R7 neighbour untouched", 5'd3, 4'h0);
  endtask

  task automatic t_comb_read;
    @(negedge clk);
    tr_raddr = 5'd26; #1;
    check("R10 same-cycle read a", {28'd0, tr_rdata}, 32'h4);
    tr_raddr = 5'd2; #1;
    check("R10 same-cycle read b", {28'd0, tr_rdata}, 32'h5);
  endtask

  initial begin
    rst_n = 1'b0; bus_valid = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    tr_raddr = '0; strobe_sw = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_sequence();
    t_no_refire();
    t_comb_read();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule